// File: doc/BRIEF.md
# Serial Character Receiver with Error Flags

This block takes an asynchronous serial line and rebuilds 7-bit characters from it. Each frame on the line is one low start bit, seven data bits with the least significant first, one parity bit and one high stop bit. The idle line is high. The receiver brings the line into its clock domain and watches for a high-to-low transition. It restarts its bit timer on that transition, confirms the start bit half a bit period later, and then takes one sample at the centre of every following bit.

The host sees one clock-wide strobe per received frame. The strobe carries the assembled character and two separate flags: one for a parity mismatch and one for a low stop bit. The character and the flags keep their values until the next frame completes. The host chooses even or odd parity with a single input. Clock frequency and line rate are parameters, and the bit period in clock cycles is derived from them.

Top module: `serial_char_rx`

## Requirements
- R1: The data bits are received least significant first: the first bit after the start bit ends up in `rx_data[0]` and the seventh ends up in `rx_data[6]`.
- R2: The line passes through a two-stage synchronizer. A falling edge at the synchronizer output starts the bit timer. The first sample is taken HALF = FULL/2 cycles later, where FULL = CLK_HZ/BAUD, and each later bit is sampled FULL cycles after the previous sample.
- R3: With `parity_odd` = 0, `parity_err` is 1 when the seven data bits plus the parity bit hold an odd number of ones. With `parity_odd` = 1, it is 1 when they hold an even number of ones.
- R4: `frame_err` is 1 when the stop bit is sampled as 0, and 0 when it is sampled as 1.
- R5: If the line is high again when the start bit is sampled, the event is dropped as a glitch and no strobe is produced.
- R6: A start bit that begins directly after a stop bit, with no idle time between them, is received.
- R7: `rx_valid` is high for exactly one clock cycle per completed frame, beginning at the clock edge that samples the stop bit.
- R8: `rx_data`, `parity_err` and `frame_err` change only together with `rx_valid`, and otherwise hold their values.
- R9: During reset, `rx_valid`, `rx_data`, `parity_err` and `frame_err` are all 0.
- R10: Because the timer restarts on every start bit, a sender whose bit period is off by about 3 percent is still decoded correctly, including back-to-back frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input; high when idle |
| parity_odd | input | 1 | Parity mode: 0 selects even, 1 selects odd |
| rx_data | output | 7 | Last character received |
| rx_valid | output | 1 | One-cycle strobe marking a completed frame |
| parity_err | output | 1 | Parity mismatch flag for the last frame |
| frame_err | output | 1 | Low stop bit flag for the last frame |

## Verification
Two situations are the hardest to reach from the ports. The first is a start edge that arrives in the first cycles after the stop bit has been sampled, when the receiver has only just gone idle. The second is a drifting sender whose sample points creep toward a bit boundary over the length of a frame. The stimulus reaches them by driving bursts of frames with no idle gap at the nominal period and at periods one cycle shorter and one cycle longer. Short low pulses of different lengths are sent as well, to exercise the glitch rejection at the half-bit check.

// File: rtl/serial_char_rx_pkg.sv
`timescale 1ns/1ps
package serial_char_rx_pkg;

   // Receiver frame position
   typedef enum logic [2:0] {
      RX_IDLE   = 3'd0,
      RX_START  = 3'd1,
      RX_DATA   = 3'd2,
      RX_PARITY = 3'd3,
      RX_STOP   = 3'd4
   } rx_state_t;

endpackage

// File: rtl/rx_line_sync.sv
`timescale 1ns/1ps
// Brings the asynchronous line into the clock domain and flags falling edges
module rx_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic fall
);

   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rx_line_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         prev  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         prev  <= chain[STAGES-1];
      end
   end

   assign level = chain[STAGES-1];
   assign fall  = prev & ~chain[STAGES-1];

endmodule

// File: rtl/rx_bit_timer.sv
`timescale 1ns/1ps
// Down-counter: restart loads the half-bit count, then ticks every full bit
module rx_bit_timer #(
   parameter int FULL = 16,
   parameter int HALF = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic tick
);

   localparam int CW = (FULL > 2) ? $clog2(FULL) : 1;

   logic [CW-1:0] cnt;

   generate
      if (HALF < 1 || HALF >= FULL) begin : g_bad_half
         $error("rx_bit_timer: HALF must lie in 1..FULL-1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart) begin
         cnt <= CW'(HALF - 1);
      end else if (run) begin
         if (cnt == '0) cnt <= CW'(FULL - 1);
         else           cnt <= cnt - 1'b1;
      end
   end

   assign tick = run && (cnt == '0);

endmodule

// File: rtl/rx_frame_ctrl.sv
`timescale 1ns/1ps
// Frame sequencer: start check, data assembly, parity and stop evaluation
module rx_frame_ctrl
   import serial_char_rx_pkg::*;
#(
   parameter int DW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          level,
   input  logic          fall,
   input  logic          tick,
   input  logic          parity_odd,
   output logic          restart,
   output logic          run,
   output rx_state_t     cur_state,
   output logic [DW-1:0] rx_data,
   output logic          rx_valid,
   output logic          parity_err,
   output logic          frame_err
);

   localparam int BW = (DW > 1) ? $clog2(DW) : 1;

   rx_state_t     state;
   logic [DW-1:0] shreg;
   logic [BW-1:0] bidx;
   logic          par_q;

   assign restart   = (state == RX_IDLE) && fall;
   assign run       = (state != RX_IDLE);
   assign cur_state = state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= RX_IDLE;
         shreg      <= '0;
         bidx       <= '0;
         par_q      <= 1'b0;
         rx_data    <= '0;
         rx_valid   <= 1'b0;
         parity_err <= 1'b0;
         frame_err  <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         case (state)
            RX_IDLE: begin
               bidx <= '0;
               if (fall) state <= RX_START;
            end
            RX_START: begin
               if (tick) state <= level ? RX_IDLE : RX_DATA;
            end
            RX_DATA: begin
               if (tick) begin
                  shreg <= {level, shreg[DW-1:1]};
                  if (bidx == BW'(DW - 1)) begin
                     bidx  <= '0;
                     state <= RX_PARITY;
                  end else begin
                     bidx <= bidx + 1'b1;
                  end
               end
            end
            RX_PARITY: begin
               if (tick) begin
                  par_q <= level;
                  state <= RX_STOP;
               end
            end
            RX_STOP: begin
               if (tick) begin
                  rx_valid   <= 1'b1;
                  rx_data    <= shreg;
                  parity_err <= (^shreg) ^ par_q ^ parity_odd;
                  frame_err  <= ~level;
                  state      <= RX_IDLE;
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/serial_char_rx.sv
`timescale 1ns/1ps
module serial_char_rx
   import serial_char_rx_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int BAUD        = 115_200,
   parameter int DATA_BITS   = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_line,
   input  logic                 parity_odd,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_valid,
   output logic                 parity_err,
   output logic                 frame_err
);

   localparam int FULL = CLK_HZ / BAUD;
   localparam int HALF = FULL / 2;

   generate
      if (FULL < 4) begin : g_bad_rate
         $error("serial_char_rx: CLK_HZ/BAUD must be at least 4");
      end
      if (DATA_BITS < 5 || DATA_BITS > 9) begin : g_bad_width
         $error("serial_char_rx: DATA_BITS must be 5..9");
      end
   endgenerate

   logic      line_level;
   logic      line_fall;
   logic      bit_tick;
   logic      tmr_restart;
   logic      tmr_run;
   rx_state_t fsm_state;

   rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (rx_line),
      .level (line_level),
      .fall  (line_fall)
   );

   rx_bit_timer #(.FULL(FULL), .HALF(HALF)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (tmr_restart),
      .run     (tmr_run),
      .tick    (bit_tick)
   );

   rx_frame_ctrl #(.DW(DATA_BITS)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .level      (line_level),
      .fall       (line_fall),
      .tick       (bit_tick),
      .parity_odd (parity_odd),
      .restart    (tmr_restart),
      .run        (tmr_run),
      .cur_state  (fsm_state),
      .rx_data    (rx_data),
      .rx_valid   (rx_valid),
      .parity_err (parity_err),
      .frame_err  (frame_err)
   );

endmodule

// File: rtl/serial_char_rx_chk.sv
`timescale 1ns/1ps
module serial_char_rx_chk
   import serial_char_rx_pkg::*;
#(
   parameter int DW = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_valid,
   input logic [DW-1:0] rx_data,
   input logic          parity_err,
   input logic          frame_err,
   input rx_state_t     fsm_state,
   input logic          line_level,
   input logic          line_fall,
   input logic          bit_tick
);

   // R7
   rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R8
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> $stable({rx_data, parity_err, frame_err}));

   // R2
   start_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_state == RX_IDLE && line_fall) |=> (fsm_state == RX_START));

   // R5
   glitch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_state == RX_START && bit_tick && line_level) |=>
         (fsm_state == RX_IDLE && !rx_valid));

   // R6
   stop_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_state == RX_STOP && bit_tick) |=> (fsm_state == RX_IDLE && rx_valid));

endmodule

bind serial_char_rx serial_char_rx_chk #(.DW(DATA_BITS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_valid   (rx_valid),
   .rx_data    (rx_data),
   .parity_err (parity_err),
   .frame_err  (frame_err),
   .fsm_state  (fsm_state),
   .line_level (line_level),
   .line_fall  (line_fall),
   .bit_tick   (bit_tick)
);

// File: tb/serial_char_rx_bench.sv
`timescale 1ns/1ps
module serial_char_rx_bench;

   localparam int CLK_HZ = 250_000_000;
   localparam int BAUD   = 7_812_500;
   localparam int FULL   = CLK_HZ / BAUD;   // 32
   localparam int HALF   = FULL / 2;        // 16

   logic       clk = 1'b0;
   logic       rst_n;
   logic       rx_line;
   logic       parity_odd;
   logic [6:0] rx_data;
   logic       rx_valid;
   logic       parity_err;
   logic       frame_err;

   always #2 clk = ~clk;

   serial_char_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_serial_char_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_line    (rx_line),
      .parity_odd (parity_odd),
      .rx_data    (rx_data),
      .rx_valid   (rx_valid),
      .parity_err (parity_err),
      .frame_err  (frame_err)
   );

   int n_chk = 0;
   int n_err = 0;
   int vcount = 0;
   int cyc = 0;
   logic [8:0] sent_q[$];   // {data, parity error, frame error}

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Behavioural timing model: delay line plus elapsed count from start edge
   logic       m_s1, m_s2, m_prev;
   bit         m_busy;
   int         m_el;
   logic [6:0] m_bits;
   logic       m_par;
   logic       e_valid;
   logic [6:0] e_data;
   logic       e_perr, e_ferr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 1; m_s2 = 1; m_prev = 1; m_busy = 0; m_el = 0;
         m_bits = 0; m_par = 0;
         e_valid = 0; e_data = 0; e_perr = 0; e_ferr = 0;
      end else begin
         e_valid = 0;
         if (m_busy) begin
            m_el++;
            if (m_el >= HALF && (m_el - HALF) % FULL == 0) begin
               int k;
               k = (m_el - HALF) / FULL;
               if (k == 0) begin
                  if (m_s2) m_busy = 0;
               end else if (k <= 7) begin
                  m_bits[k-1] = m_s2;
               end else if (k == 8) begin
                  m_par = m_s2;
               end else begin
                  e_valid = 1;
                  e_data  = m_bits;
                  e_perr  = (^m_bits) ^ m_par ^ parity_odd;
                  e_ferr  = !m_s2;
                  m_busy  = 0;
               end
            end
         end else if (m_prev && !m_s2) begin
            m_busy = 1;
            m_el   = 0;
         end
         m_prev = m_s2;
         m_s2   = m_s1;
         m_s1   = rx_line;
      end
   end

   // Per-clock comparison away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         check(0, "WATCHDOG", "run did not finish", cyc, 150000);
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
      if (rst_n === 1'b1) begin
         check(rx_valid === e_valid, "R7", "strobe vs model", rx_valid, e_valid);
         check(rx_data === e_data, e_valid ? "R1" : "R8", "data vs model", rx_data, e_data);
         check(parity_err === e_perr, e_valid ? "R3" : "R8", "parity flag vs model",
               parity_err, e_perr);
         check(frame_err === e_ferr, e_valid ? "R4" : "R8", "frame flag vs model",
               frame_err, e_ferr);
         if (rx_valid === 1'b1) begin
            vcount++;
            if (sent_q.size() == 0) begin
               check(0, "R5", "strobe without a sent frame", 1, 0);
            end else begin
               logic [8:0] ex;
               ex = sent_q.pop_front();
               check(rx_data === ex[8:2], "R1", "data vs sent", rx_data, ex[8:2]);
               check(parity_err === ex[1], "R3", "parity vs sent", parity_err, ex[1]);
               check(frame_err === ex[0], "R4", "stop vs sent", frame_err, ex[0]);
            end
         end
      end
   end

   task automatic hold_line(input logic v, input int n);
      rx_line = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_frame(input logic [6:0] d, input bit bad_par,
                             input bit stop_val, input int per, input int gap);
      logic par;
      par = (^d) ^ parity_odd ^ bad_par;
      sent_q.push_back({d, bad_par, !stop_val});
      hold_line(1'b0, per);
      for (int i = 0; i < 7; i++) hold_line(d[i], per);
      hold_line(par, per);
      hold_line(stop_val, per);
      if (gap > 0) hold_line(1'b1, gap);
   endtask

   initial begin
      int v0;
      rst_n = 1'b0;
      rx_line = 1'b1;
      parity_odd = 1'b0;
      repeat (5) @(negedge clk);
      // R9
      check(rx_valid === 1'b0, "R9", "strobe in reset", rx_valid, 0);
      check(rx_data === 7'd0, "R9", "data in reset", rx_data, 0);
      check(parity_err === 1'b0 && frame_err === 1'b0, "R9", "flags in reset",
            {parity_err, frame_err}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 R2 R3: even then odd parity, nominal rate
      for (int i = 0; i < 6; i++) send_frame(7'($urandom_range(0, 127)), 0, 1, FULL, 7);
      parity_odd = 1'b1;
      for (int i = 0; i < 6; i++) send_frame(7'($urandom_range(0, 127)), 0, 1, FULL, 5);
      // R1: boundary patterns
      send_frame(7'h00, 0, 1, FULL, 3);
      send_frame(7'h7F, 0, 1, FULL, 3);
      send_frame(7'h01, 0, 1, FULL, 3);
      send_frame(7'h40, 0, 1, FULL, 3);
      // R3: wrong parity in both modes
      send_frame(7'h55, 1, 1, FULL, 4);
      parity_odd = 1'b0;
      send_frame(7'h2A, 1, 1, FULL, 4);
      send_frame(7'h00, 1, 1, FULL, 4);
      // R4: low stop bit, then a clean frame
      send_frame(7'h33, 0, 0, FULL, FULL);
      send_frame(7'h4C, 1, 0, FULL, FULL);
      send_frame(7'h66, 0, 1, FULL, 4);

      // R5: short low pulses rejected
      repeat (FULL) @(negedge clk);
      v0 = vcount;
      hold_line(1'b0, 2);
      hold_line(1'b1, 2 * FULL);
      hold_line(1'b0, HALF - 5);
      hold_line(1'b1, 2 * FULL);
      check(vcount == v0, "R5", "strobes after glitches", vcount, v0);
      send_frame(7'h5A, 0, 1, FULL, 4);

      // R6: back-to-back burst with no idle gap
      v0 = vcount;
      for (int i = 0; i < 8; i++) send_frame(7'($urandom_range(0, 127)), 0, 1, FULL, 0);
      hold_line(1'b1, 2 * FULL);
      check(vcount == v0 + 8, "R6", "back-to-back frames received", vcount, v0 + 8);

      // R10: sender off-rate, slow and fast, back-to-back
      v0 = vcount;
      parity_odd = 1'b1;
      for (int i = 0; i < 6; i++) send_frame(7'($urandom_range(0, 127)), 0, 1, FULL + 1, 0);
      hold_line(1'b1, FULL);
      for (int i = 0; i < 6; i++) send_frame(7'($urandom_range(0, 127)), 0, 1, FULL - 1, 0);
      hold_line(1'b1, 2 * FULL);
      check(vcount == v0 + 12, "R10", "off-rate frames received", vcount, v0 + 12);

      repeat (100) @(negedge clk);
      check(sent_q.size() == 0, "R1", "frames left unreceived", sent_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule